// File: doc/BRIEF.md
# Four-Phase Handshake Pipeline Stage

This block is one stage of a self-timed pipeline, modelled with synchronous logic on a single clock. On its upstream side it receives a data word with a request/acknowledge pair. On its downstream side it offers a result word with a second request/acknowledge pair. Both sides use the four-phase return-to-zero protocol. The request rises with valid data, the acknowledge rises, the request falls, and the acknowledge falls. Only after that sequence completes may a new word be offered.

The control state sits in two rendezvous registers that follow C-element rules. Such a register rises when both of its inputs are high, falls when both are low, and otherwise holds its value. The first one accepts an incoming request and captures the word. Its output also serves as the upstream acknowledge. The second one launches the function unit. It can only do so while the word is held and the downstream acknowledge is low. A down-counter stands in for a delay line matched to the function's worst-case delay. When it expires, the stage presents the result and raises its downstream request. The stage accepts no new word until the downstream side has taken the current result and returned its acknowledge to zero.

Top module: `hs_pipe_stage`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, `in_ack` and `out_req` are 0 and `out_data` is 0.
- R2: When `in_req` is 1, `out_ack` is 0 and `in_ack` is 0 at a clock edge, `in_ack` is 1 after that edge.
- R3: While `out_ack` is 1, `in_ack` does not rise. A new word is never accepted before the downstream acknowledge has returned to zero.
- R4: `out_req` rises exactly DELAY_CYCLES+3 clock cycles after the `in_ack` rise of the same word. With the default DELAY_CYCLES of 3, this is 6 cycles. The work is launched only while `out_ack` is 0.
- R5: `out_data` equals the accepted word plus ADD_CONST, modulo 2^DATA_W. With the defaults this is an 8-bit add of 5, so 0xFF gives 0x04. `out_data` stays stable from the rise of `out_req` until `out_req` falls.
- R6: Every accepted word appears at the output exactly once, in the order of acceptance.
- R7: `in_ack` falls only after a cycle in which `in_req` was 0 and `out_ack` was 1.
- R8: `out_req` falls only after a cycle in which `out_ack` was 1.
- R9: `out_req` rises only after a cycle in which `out_ack` was 0.
- R10: The word is captured on the edge where `in_ack` rises. Later changes on `in_data` have no effect on `out_data`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_req | input | 1 | Upstream request; data valid while high |
| in_data | input | DATA_W | Upstream data word |
| in_ack | output | 1 | Upstream acknowledge (word held) |
| out_req | output | 1 | Downstream request; result valid while high |
| out_data | output | DATA_W | Result word |
| out_ack | input | 1 | Downstream acknowledge |

## Verification
Upstream idle gaps and request hold times, and downstream acknowledge delays, are drawn at random for each word. This separates a stage that sequences strictly through its handshake from one that happens to work only when both neighbours respond at once.

Slow downstream acknowledges keep `out_ack` high while a new request is already waiting. That exposes any premature acceptance (R3) and any lost or duplicated word (R6).

`in_data` is scrambled as soon as the word has been acknowledged. Any capture later than the acceptance edge would therefore show up as wrong output data (R10).

The first word is 0xFF, so the result wraps around.

// File: rtl/hs_pkg.sv
// Package: shared helpers for the four-phase handshake stage.
// Assumes: nothing beyond IEEE 1800-2017 constant functions.
package hs_pkg;

    // Width of a down-counter that must hold values 0..max_val.
    function automatic int unsigned cnt_width(input int unsigned max_val);
        int unsigned w;
        w = 1;
        while ((1 << w) <= max_val) w++;
        return w;
    endfunction

endpackage

// File: rtl/hs_c_element.sv
// Module: rendezvous register with C-element behaviour.
// The output rises when both inputs are high, falls when both are low,
// and otherwise holds. Assumes synchronous active-low reset to 0.
module hs_c_element (
    input  logic clk,
    input  logic rst_n,
    input  logic a,
    input  logic b,
    output logic q
);

    // Update the held state: set on agreement high, clear on agreement low.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (a && b)
            q <= 1'b1;
        else if (!a && !b)
            q <= 1'b0;
    end

endmodule

// File: rtl/hs_delay_line.sv
// Module: matched-delay model. Loads DELAY_CYCLES into a down-counter on
// the first cycle Start is seen high, raises Done when it reaches zero and
// clears Done as soon as Start is low. Assumes DELAY_CYCLES >= 1.
module hs_delay_line #(
    parameter int unsigned DELAY_CYCLES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);
    import hs_pkg::*;

    localparam int unsigned CW = cnt_width(DELAY_CYCLES);

    logic [CW-1:0] cnt_q;
    logic          start_seen_q;

    // Count down from the load value while Start stays high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q        <= '0;
            done         <= 1'b0;
            start_seen_q <= 1'b0;
        end else begin
            start_seen_q <= start;
            if (start && !start_seen_q) begin
                cnt_q <= CW'(DELAY_CYCLES);
                done  <= 1'b0;
            end else if (!start) begin
                cnt_q <= '0;
                done  <= 1'b0;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1))
                    done <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/hs_func_unit.sv
// Module: placeholder function unit, a modular add of a constant.
// Purely combinational; its worst-case delay is modelled by hs_delay_line.
module hs_func_unit #(
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned ADD_CONST = 5
) (
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout
);

    // Compute the result; wraps modulo 2^DATA_W.
    always_comb dout = din + DATA_W'(ADD_CONST);

endmodule

// File: rtl/hs_pipe_stage.sv
// Module: one four-phase handshake pipeline stage.
// Accept rendezvous (in_req, not out_ack) captures the word and acknowledges
// upstream; launch rendezvous (held, not out_ack) starts the function; the
// delay model's Done raises out_req with the registered result. out_req
// drops once the launch state has fallen. Assumes both neighbours obey the
// four-phase protocol; all control resets to zero.
module hs_pipe_stage #(
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned DELAY_CYCLES = 3,
    parameter int unsigned ADD_CONST    = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_req,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ack,
    output logic              out_req,
    output logic [DATA_W-1:0] out_data,
    input  logic              out_ack
);

    logic              hold_q;
    logic              launch_q;
    logic              done;
    logic              capture;
    logic [DATA_W-1:0] word_q;
    logic [DATA_W-1:0] result;
    logic              oreq_q;
    logic [DATA_W-1:0] odata_q;

    // Accept rendezvous: request present and downstream acknowledge low.
    hs_c_element u_accept (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (in_req),
        .b     (!out_ack),
        .q     (hold_q)
    );

    // Launch rendezvous: word held and downstream acknowledge low.
    hs_c_element u_launch (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (hold_q),
        .b     (!out_ack),
        .q     (launch_q)
    );

    // Enable pulse: the edge at which the accept state goes high.
    always_comb capture = in_req && !out_ack && !hold_q;

    // Data latch, loaded only on the enable pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)
            word_q <= '0;
        else if (capture)
            word_q <= in_data;
    end

    hs_func_unit #(
        .DATA_W    (DATA_W),
        .ADD_CONST (ADD_CONST)
    ) u_func (
        .din  (word_q),
        .dout (result)
    );

    hs_delay_line #(
        .DELAY_CYCLES (DELAY_CYCLES)
    ) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .start (launch_q),
        .done  (done)
    );

    // Output request and result register: set on Done, clear after launch falls.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            oreq_q  <= 1'b0;
            odata_q <= '0;
        end else if (done && !oreq_q) begin
            oreq_q  <= 1'b1;
            odata_q <= result;
        end else if (!launch_q) begin
            oreq_q  <= 1'b0;
        end
    end

    assign in_ack   = hold_q;
    assign out_req  = oreq_q;
    assign out_data = odata_q;

endmodule

// File: rtl/hs_pipe_stage_chk.sv
// Checker: protocol-phase properties of hs_pipe_stage, attached by bind.
// Assumes synchronous active-low reset; all properties disabled in reset.
module hs_pipe_stage_chk #(
    parameter int unsigned DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_req,
    input logic              in_ack,
    input logic              out_req,
    input logic              out_ack,
    input logic [DATA_W-1:0] out_data,
    input logic              launch
);

    // R2: an offered request into an idle stage is acknowledged next cycle.
    a_r2_accept: assert property (@(posedge clk) disable iff (!rst_n)
        in_req && !out_ack && !in_ack |=> in_ack);

    // R3: no acceptance while the downstream acknowledge is high.
    a_r3_no_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_ack && !in_ack |=> !in_ack);

    // R4: the function is not launched while the downstream acknowledge is high.
    a_r4_no_launch_busy: assert property (@(posedge clk) disable iff (!rst_n)
        out_ack && !launch |=> !launch);

    // R5: result held while the request waits for its acknowledge.
    a_r5_data_stable: assert property (@(posedge clk) disable iff (!rst_n)
        out_req && !out_ack |=> $stable(out_data));

    // R7: upstream acknowledge returns low only after request low and downstream taken.
    a_r7_ack_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_ack) |-> $past(!in_req && out_ack));

    // R8: output request falls only after the downstream acknowledge.
    a_r8_req_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(out_req) |-> $past(out_ack));

    // R9: output request rises only with the downstream acknowledge low.
    a_r9_req_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_req) |-> $past(!out_ack));

endmodule

bind hs_pipe_stage hs_pipe_stage_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .out_req  (out_req),
    .out_ack  (out_ack),
    .out_data (out_data),
    .launch   (launch_q)
);

// File: tb/hs_pipe_stage_tb.sv
// Bench: random upstream/downstream timing, queue-based reference model,
// per-clock protocol and data comparison at the falling edge.
module hs_pipe_stage_tb;

    localparam int DATA_W = 8;
    localparam int DELAY  = 3;
    localparam int ADDC   = 5;
    localparam int NWORDS = 40;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_req = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ack;
    logic              out_req;
    logic [DATA_W-1:0] out_data;
    logic              out_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [DATA_W-1:0] exp_q[$];
    int received = 0;
    bit done_up = 0;
    bit done_dn = 0;

    always #10 clk = ~clk;

    hs_pipe_stage #(.DATA_W(DATA_W), .DELAY_CYCLES(DELAY), .ADD_CONST(ADDC)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_req(in_req), .in_data(in_data),
        .in_ack(in_ack), .out_req(out_req), .out_data(out_data), .out_ack(out_ack)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Upstream sender.
    initial begin
        @(posedge rst_n);
        for (int i = 0; i < NWORDS; i++) begin
            logic [DATA_W-1:0] w;
            w = (i == 0) ? 8'hFF : DATA_W'($urandom);
            repeat ($urandom % 4) @(posedge clk);
            @(posedge clk); #2;
            in_data = w;
            in_req  = 1'b1;
            exp_q.push_back(w + DATA_W'(ADDC));
            do @(negedge clk); while (!in_ack);
            in_data = DATA_W'($urandom);   // R10: scramble after acceptance
            repeat ($urandom % 3) @(posedge clk);
            @(posedge clk); #2;
            in_req  = 1'b0;
            in_data = DATA_W'($urandom);
            do @(negedge clk); while (in_ack);
        end
        done_up = 1;
    end

    // Downstream receiver.
    initial begin
        @(posedge rst_n);
        for (int i = 0; i < NWORDS; i++) begin
            do @(negedge clk); while (!out_req);
            repeat ($urandom % 5) @(posedge clk);
            @(posedge clk); #2;
            out_ack = 1'b1;
            do @(negedge clk); while (out_req);
            repeat ($urandom % 3) @(posedge clk);
            @(posedge clk); #2;
            out_ack = 1'b0;
        end
        done_dn = 1;
    end

    // Reference comparison every clock, away from the active edge.
    int cyc = 0;
    int ack_rise_cyc = 0;
    bit p_in_req = 0, p_in_ack = 0, p_out_req = 0, p_out_ack = 0;
    logic [DATA_W-1:0] p_out_data = '0;
    bit first = 1;
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (first) begin
                check(in_ack == 0 && out_req == 0 && out_data == 0, "R1",
                      {in_ack, out_req}, 0);
                first = 0;
            end
            if (p_in_req && !p_out_ack && !p_in_ack)
                check(in_ack == 1, "R2", in_ack, 1);
            if (p_out_ack && !p_in_ack)
                check(in_ack == 0, "R3", in_ack, 0);
            if (in_ack && !p_in_ack)
                ack_rise_cyc = cyc;
            if (!in_ack && p_in_ack)
                check(!p_in_req && p_out_ack, "R7", {p_in_req, p_out_ack}, 1);
            if (out_req && !p_out_req) begin
                check(!p_out_ack, "R9", p_out_ack, 0);
                check(cyc - ack_rise_cyc == DELAY + 3, "R4",
                      cyc - ack_rise_cyc, DELAY + 3);
                if (exp_q.size() == 0)
                    check(0, "R6", received, exp_q.size());
                else begin
                    logic [DATA_W-1:0] e;
                    e = exp_q.pop_front();
                    check(out_data == e, "R5/R6/R10", out_data, e);
                end
                received++;
            end
            if (out_req && p_out_req)
                check(out_data == p_out_data, "R5", out_data, p_out_data);
            if (!out_req && p_out_req)
                check(p_out_ack, "R8", p_out_ack, 1);
            p_in_req = in_req; p_in_ack = in_ack;
            p_out_req = out_req; p_out_ack = out_ack; p_out_data = out_data;
        end
    end

    // Reset, run, watchdog and summary.
    initial begin
        repeat (3) @(negedge clk);
        check(in_ack == 0 && out_req == 0 && out_data == 0, "R1",
              {in_ack, out_req}, 0);
        @(posedge clk); #2;
        rst_n = 1'b1;
        fork
            wait (done_up && done_dn);
            begin
                repeat (100000) @(posedge clk);
                check(0, "watchdog", 0, 1);
            end
        join_any
        disable fork;
        repeat (4) @(negedge clk);
        check(received == NWORDS && exp_q.size() == 0, "R6", received, NWORDS);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule